// File: doc/BRIEF.md
# Text Command Line Classifier

This block sits behind a UART receiver and turns a stream of ASCII bytes into classified command lines. Each line has to open with the two letters `AT`. After them comes either nothing (the bare attention command) or a `+` and a command name. The name may be followed by `?` to ask for the current value, by `=?` to ask which values are allowed, or by `=` and a list of comma-separated fields, in which double-quoted strings are allowed. A line ends on CR or LF.

When a line is complete, the block presents one result on a valid/ready output. The result carries a numeric command code, the syntactic form, an error code, the number of fields, and the raw field text. While a result waits to be taken, the block deasserts `rx_ready`, so the UART side holds its next byte. The block does not execute any command and produces no response text. The part that executes commands consumes the result.

Top module: `atline_classifier`

## Requirements
- R1: After reset, `cmd_valid` is 0 and `rx_ready` is 1.
- R2: A line of just `AT` gives code 0, form plain, error 0 and 0 fields. A CR or LF with no text in front of it produces no result, so a CR LF pair yields exactly one result. A result is presented in the cycle after its line-ending byte is accepted.
- R3: The prefix and the name are matched without regard to case. Names and codes: CIFSR=1, CIPCLOSE=2, CIPMUX=3, CIPSEND=4, CIPSERVER=5, CIPSTART=6, CIPSTATUS=7, CWJAP=8, CWLAP=9, CWMODE=10, CWQAP=11, CWSAP=12, RST=13.
- R4: The form code is 0 for a plain line, 1 for `NAME=...`, 2 for `NAME?` and 3 for `NAME=?`. Any character between `?` or `=?` and the line end gives error 3 (syntax). With no error, the field count is nonzero exactly when the form is 1.
- R5: For form 1, `cmd_params` holds the raw text after `=`, quotes included. The first byte is at bits [7:0] and each following byte sits 8 bits higher. `cmd_len` is its byte count, and the bytes beyond `cmd_len` are 0. `cmd_nparams` is one more than the number of commas outside quotes.
- R6: A comma inside quotes is field text. A quote may open only at the start of a field, and a closing quote must be followed by a comma or the line end. Any other placement gives error 3.
- R7: A space directly after an opening quote, a space directly before a closing quote, or a line that ends inside quotes gives error 3.
- R8: An unknown name, an empty name, a name longer than 9 characters or a non-alphanumeric name character gives error 2 with code 15.
- R9: A line whose first two characters are not `A`,`T` gives error 1 with code 15.
- R10: A set line is range checked, giving error 4 on failure. For CWMODE, the first field must be a plain decimal 1 to 3. The first field is a connection id, which must be a plain decimal 0 to 4, in three cases: always for CIPCLOSE, for CIPSTART when that field is unquoted, and for CIPSEND when there are 2 or more fields.
- R11: More than BUF_BYTES (default 32) field bytes, or more than MAX_PARAMS (default 5) fields, gives error 5. The rest of the line is dropped up to its end, one result is still given, and the next line is parsed normally.
- R12: While `cmd_valid` is high and `cmd_ready` is low, the result holds stable and `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received ASCII byte |
| rx_ready | output | 1 | Byte accepted this cycle when high with rx_valid |
| cmd_valid | output | 1 | Result present |
| cmd_ready | input | 1 | Consumer takes the result |
| cmd_code | output | 4 | Command code (0 bare, 15 none) |
| cmd_form | output | 2 | 0 plain, 1 set, 2 inquiry, 3 test |
| cmd_err | output | 3 | 0 ok, 1 prefix, 2 name, 3 syntax, 4 range, 5 overflow |
| cmd_nparams | output | 3 | Field count |
| cmd_len | output | 6 | Field text length in bytes |
| cmd_params | output | 256 | Field text, byte 0 lowest |

## Verification
The bench targets the following corner cases, each paired with the failure it exposes:
- **Spaces next to quotes:** spaces on either side of a quoted value are sent. A parser that trims them would accept a line that must be rejected.
- **Commas inside quotes:** a design that splits on every comma would report the wrong field count.
- **Buffer boundary:** the text is sent at exactly 32 bytes and again at 33 bytes. An off-by-one design would either reject a legal line or overwrite the buffer.
- **Context-dependent id rule:** the id check depends on the command and on whether the first field is quoted, as in the single- and multi-connection forms of CIPSTART and CIPSEND. A design that applies one rule everywhere would flag legal lines or miss bad ids.
- **Empty lines and held results:** a CR LF pair must not give a phantom result. A result left waiting under backpressure must not change before it is taken.

// File: rtl/atl_pkg.sv
package atl_pkg;
    localparam int NAME_MAX  = 9;
    localparam int NAME_BITS = 8 * NAME_MAX;
    localparam int NUM_CMDS  = 14;
    localparam int CODE_W    = 4;

    localparam logic [CODE_W-1:0] CODE_BARE   = CODE_W'(0);
    localparam logic [CODE_W-1:0] CODE_NONE   = CODE_W'(15);
    localparam logic [CODE_W-1:0] C_CIPCLOSE  = CODE_W'(2);
    localparam logic [CODE_W-1:0] C_CIPSEND   = CODE_W'(4);
    localparam logic [CODE_W-1:0] C_CIPSTART  = CODE_W'(6);
    localparam logic [CODE_W-1:0] C_CWMODE    = CODE_W'(10);

    typedef enum logic [1:0] {FORM_PLAIN, FORM_SET, FORM_QUERY, FORM_TEST} form_t;
    typedef enum logic [2:0] {ERR_NONE, ERR_PREFIX, ERR_NAME, ERR_SYNTAX,
                              ERR_RANGE, ERR_OVF} err_t;
    typedef enum logic [3:0] {S_IDLE, S_A, S_T, S_NAME, S_QRY, S_TEST,
                              S_PARAM, S_QUOTE, S_QEND, S_DISC} state_t;

    // Right-aligned, zero-padded name for each code; index 0 is the bare line.
    function automatic logic [NAME_BITS-1:0] cmd_name(input int idx);
        case (idx)
            1:       return NAME_BITS'("CIFSR");
            2:       return NAME_BITS'("CIPCLOSE");
            3:       return NAME_BITS'("CIPMUX");
            4:       return NAME_BITS'("CIPSEND");
            5:       return NAME_BITS'("CIPSERVER");
            6:       return NAME_BITS'("CIPSTART");
            7:       return NAME_BITS'("CIPSTATUS");
            8:       return NAME_BITS'("CWJAP");
            9:       return NAME_BITS'("CWLAP");
            10:      return NAME_BITS'("CWMODE");
            11:      return NAME_BITS'("CWQAP");
            12:      return NAME_BITS'("CWSAP");
            13:      return NAME_BITS'("RST");
            default: return '0;
        endcase
    endfunction

    function automatic logic [7:0] upcase(input logic [7:0] c);
        return (c >= "a" && c <= "z") ? c - 8'h20 : c;
    endfunction

    function automatic logic is_digit(input logic [7:0] c);
        return (c >= "0" && c <= "9");
    endfunction

    function automatic logic is_alnum(input logic [7:0] c);
        return is_digit(c) || (upcase(c) >= "A" && upcase(c) <= "Z");
    endfunction
endpackage

// File: rtl/at_name_match.sv
module at_name_match
    import atl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NAME_BITS-1:0] name_i,
    output logic                 hit_o,
    output logic [CODE_W-1:0]    code_o
);
    logic [NUM_CMDS-1:0] hits;

    assign hits[0] = 1'b0;
    for (genvar i = 1; i < NUM_CMDS; i++) begin : g_cmp
        assign hits[i] = (name_i == cmd_name(i));
    end

    always_comb begin
        code_o = CODE_NONE;
        for (int i = 1; i < NUM_CMDS; i++) begin
            if (hits[i]) code_o = CODE_W'(i);
        end
    end

    assign hit_o = |hits;

    // R3
    name_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hits));
endmodule

// File: rtl/at_range_check.sv
module at_range_check
    import atl_pkg::*;
#(
    parameter int PCW = 3
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [PCW-1:0]    pcnt_i,
    input  logic [4:0]        f1_num_i,
    input  logic              f1_dig_i,
    input  logic              f1_quoted_i,
    output logic              bad_o
);
    logic id_bad;
    assign id_bad = !f1_dig_i || (f1_num_i > 5'd4);

    always_comb begin
        bad_o = 1'b0;
        case (code_i)
            C_CWMODE:   bad_o = !f1_dig_i || (f1_num_i < 5'd1) || (f1_num_i > 5'd3);
            C_CIPCLOSE: bad_o = id_bad;
            C_CIPSTART: bad_o = !f1_quoted_i && id_bad;
            C_CIPSEND:  bad_o = (pcnt_i >= PCW'(2)) && id_bad;
            default:    bad_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/atline_classifier.sv
module atline_classifier
    import atl_pkg::*;
#(
    parameter int BUF_BYTES  = 32,
    parameter int MAX_PARAMS = 5,
    localparam int PCW = $clog2(MAX_PARAMS + 1),
    localparam int LW  = $clog2(BUF_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    output logic                   rx_ready,
    output logic                   cmd_valid,
    input  logic                   cmd_ready,
    output logic [CODE_W-1:0]      cmd_code,
    output logic [1:0]             cmd_form,
    output logic [2:0]             cmd_err,
    output logic [PCW-1:0]         cmd_nparams,
    output logic [LW-1:0]          cmd_len,
    output logic [BUF_BYTES*8-1:0] cmd_params
);
    localparam int NLW = $clog2(NAME_MAX + 1);

    typedef struct packed {
        state_t                 st;
        logic [NAME_BITS-1:0]   name;
        logic [NLW-1:0]         nlen;
        logic [CODE_W-1:0]      code;
        form_t                  form;
        err_t                   err;
        logic [PCW-1:0]         pcnt;
        logic [LW-1:0]          plen;
        logic [BUF_BYTES*8-1:0] pbuf;
        logic                   fstart;
        logic                   qfirst;
        logic                   pspace;
        logic [4:0]             f1num;
        logic                   f1dig;
        logic                   f1q;
        logic                   ov;
    } regs_t;

    regs_t q, d;
    logic take, eol, dig, wr, comma, fin, m_hit, rng_bad;
    logic [7:0] ch;
    logic [4:0] base;
    logic [CODE_W-1:0] m_code;

    at_name_match u_match (
        .clk(clk), .rst_n(rst_n), .name_i(q.name), .hit_o(m_hit), .code_o(m_code)
    );

    at_range_check #(.PCW(PCW)) u_range (
        .code_i(q.code), .pcnt_i(q.pcnt), .f1_num_i(q.f1num), .f1_dig_i(q.f1dig),
        .f1_quoted_i(q.f1q), .bad_o(rng_bad)
    );

    assign rx_ready = !q.ov;
    assign take     = rx_valid && rx_ready;
    assign ch       = upcase(rx_data);
    assign eol      = (rx_data == 8'h0D) || (rx_data == 8'h0A);
    assign dig      = is_digit(rx_data);
    assign base     = q.fstart ? 5'd0 : q.f1num;

    always_comb begin
        d     = q;
        wr    = 1'b0;
        comma = 1'b0;
        fin   = 1'b0;
        if (q.ov && cmd_ready) d.ov = 1'b0;
        if (take) begin
            case (q.st)
                S_IDLE: if (!eol) begin
                    d.name  = '0;  d.nlen = '0;  d.code = CODE_NONE;
                    d.form  = FORM_PLAIN;  d.err = ERR_NONE;
                    d.pcnt  = '0;  d.plen = '0;  d.pbuf = '0;
                    d.f1num = '0;  d.f1dig = 1'b0;  d.f1q = 1'b0;
                    if (ch == "A") d.st = S_A;
                    else begin d.st = S_DISC; d.err = ERR_PREFIX; end
                end
                S_A: begin
                    if (eol) begin fin = 1'b1; d.err = ERR_PREFIX; end
                    else if (ch == "T") d.st = S_T;
                    else begin d.st = S_DISC; d.err = ERR_PREFIX; end
                end
                S_T: begin
                    if (eol) begin fin = 1'b1; d.code = CODE_BARE; end
                    else if (rx_data == "+") d.st = S_NAME;
                    else begin d.st = S_DISC; d.err = ERR_NAME; end
                end
                S_NAME: begin
                    if (eol) begin
                        fin    = 1'b1;
                        d.code = m_hit ? m_code : CODE_NONE;
                        d.err  = m_hit ? ERR_NONE : ERR_NAME;
                    end else if ((rx_data == "?" || rx_data == "=") && m_hit) begin
                        d.code = m_code;
                        if (rx_data == "?") begin
                            d.form = FORM_QUERY; d.st = S_QRY;
                        end else begin
                            d.form = FORM_SET; d.st = S_PARAM; d.pcnt = PCW'(1);
                            d.fstart = 1'b1; d.f1dig = 1'b0; d.f1q = 1'b0;
                        end
                    end else if (is_alnum(rx_data) && q.nlen != NLW'(NAME_MAX)) begin
                        d.name = {q.name[NAME_BITS-9:0], ch};
                        d.nlen = q.nlen + 1'b1;
                    end else begin
                        d.st = S_DISC; d.err = ERR_NAME;
                    end
                end
                S_QRY, S_TEST: begin
                    if (eol) fin = 1'b1;
                    else begin d.st = S_DISC; d.err = ERR_SYNTAX; end
                end
                S_PARAM: begin
                    if (eol) begin
                        fin = 1'b1; d.err = rng_bad ? ERR_RANGE : ERR_NONE;
                    end else if (rx_data == "?" && q.plen == '0) begin
                        d.form = FORM_TEST; d.st = S_TEST; d.pcnt = '0;
                    end else if (rx_data == ",") begin
                        comma = 1'b1; wr = 1'b1; d.fstart = 1'b1;
                    end else if (rx_data == "\"") begin
                        if (q.fstart) begin
                            wr = 1'b1; d.st = S_QUOTE; d.qfirst = 1'b1;
                            d.pspace = 1'b0; d.fstart = 1'b0;
                            if (q.pcnt == PCW'(1)) d.f1q = 1'b1;
                        end else begin
                            d.st = S_DISC; d.err = ERR_SYNTAX;
                        end
                    end else begin
                        wr = 1'b1; d.fstart = 1'b0;
                        if (q.pcnt == PCW'(1)) begin
                            d.f1dig = (q.fstart || q.f1dig) && dig;
                            if (dig) d.f1num = (base > 5'd2) ? 5'd31
                                             : 5'(base * 5'd10 + {1'b0, rx_data[3:0]});
                        end
                    end
                end
                S_QUOTE: begin
                    if (eol) begin
                        fin = 1'b1; d.err = ERR_SYNTAX;
                    end else if (rx_data == "\"") begin
                        if (q.pspace) begin d.st = S_DISC; d.err = ERR_SYNTAX; end
                        else begin wr = 1'b1; d.st = S_QEND; end
                    end else if (rx_data == " " && q.qfirst) begin
                        d.st = S_DISC; d.err = ERR_SYNTAX;
                    end else begin
                        wr = 1'b1; d.qfirst = 1'b0; d.pspace = (rx_data == " ");
                    end
                end
                S_QEND: begin
                    if (eol) begin
                        fin = 1'b1; d.err = rng_bad ? ERR_RANGE : ERR_NONE;
                    end else if (rx_data == ",") begin
                        comma = 1'b1; wr = 1'b1; d.fstart = 1'b1; d.st = S_PARAM;
                    end else begin
                        d.st = S_DISC; d.err = ERR_SYNTAX;
                    end
                end
                S_DISC:  if (eol) fin = 1'b1;
                default: d.st = S_IDLE;
            endcase

            if (wr) begin
                if (q.plen == LW'(BUF_BYTES)) begin
                    d.st = S_DISC; d.err = ERR_OVF;
                end else begin
                    d.pbuf[int'(q.plen)*8 +: 8] = rx_data;
                    d.plen = q.plen + 1'b1;
                end
            end
            if (comma) begin
                if (q.pcnt == PCW'(MAX_PARAMS)) begin d.st = S_DISC; d.err = ERR_OVF; end
                else d.pcnt = q.pcnt + 1'b1;
            end
            if (fin) begin d.ov = 1'b1; d.st = S_IDLE; end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_valid   = q.ov;
    assign cmd_code    = q.code;
    assign cmd_form    = q.form;
    assign cmd_err     = q.err;
    assign cmd_nparams = q.pcnt;
    assign cmd_len     = q.plen;
    assign cmd_params  = q.pbuf;

    // R12
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_err)
            && $stable(cmd_form) && $stable(cmd_nparams) && $stable(cmd_len));
    // R2
    result_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(rx_valid && rx_ready));
    // R11
    bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_len <= LW'(BUF_BYTES) && cmd_nparams <= PCW'(MAX_PARAMS));
    // R8
    code_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_err == ERR_PREFIX || cmd_err == ERR_NAME) |-> cmd_code == CODE_NONE);
    // R4
    form_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_err == ERR_NONE |-> (cmd_form == FORM_SET) == (cmd_nparams != '0));
endmodule

// File: tb/atline_classifier_tb_top.sv
module atline_classifier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BUF_BYTES  = 32;
    localparam int MAX_PARAMS = 5;

    typedef struct {
        int    code;
        int    form;
        int    err;
        int    np;
        string txt;
        bit    full;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic rx_ready, cmd_valid;
    logic cmd_ready = 1'b0;
    logic [3:0] cmd_code;
    logic [1:0] cmd_form;
    logic [2:0] cmd_err;
    logic [2:0] cmd_nparams;
    logic [5:0] cmd_len;
    logic [BUF_BYTES*8-1:0] cmd_params;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    exp_t sb[$];

    atline_classifier #(.BUF_BYTES(BUF_BYTES), .MAX_PARAMS(MAX_PARAMS)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_form(cmd_form), .cmd_err(cmd_err),
        .cmd_nparams(cmd_nparams), .cmd_len(cmd_len), .cmd_params(cmd_params)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        while (!rx_ready) @(negedge clk);
    endtask

    task automatic send(input string s, input bit expect_res, input string req);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
        @(negedge clk);
        rx_valid = 1'b0;
        if (expect_res) check(cmd_valid === 1'b1, req, "valid after line end", int'(cmd_valid), 1);
    endtask

    task automatic ok_line(input string req, input string s, input int code,
                           input int form, input int np, input string txt);
        exp_t e;
        e.code = code; e.form = form; e.err = 0; e.np = np; e.txt = txt;
        e.full = 1'b1; e.req = req;
        sb.push_back(e);
        send(s, 1'b1, req);
    endtask

    task automatic err_line(input string req, input string s, input int code, input int err);
        exp_t e;
        e.code = code; e.form = 0; e.err = err; e.np = 0; e.txt = "";
        e.full = 1'b0; e.req = req;
        sb.push_back(e);
        send(s, 1'b1, req);
    endtask

    // Monitor and scoreboard: drives cmd_ready with a backpressure pattern.
    initial begin
        logic held;
        logic [3:0] p_code;
        logic [2:0] p_err;
        logic [5:0] p_len;
        held = 1'b0; p_code = '0; p_err = '0; p_len = '0;
        forever begin
            @(negedge clk);
            cyc++;
            cmd_ready = (cyc % 3 != 0);
            if (held) begin
                // R12: held result unchanged
                check(cmd_valid === 1'b1 && cmd_code == p_code && cmd_err == p_err
                      && cmd_len == p_len, "R12", "held result code", int'(cmd_code), int'(p_code));
            end
            if (cmd_valid && cmd_ready) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected result code", int'(cmd_code), -1);
                end else begin
                    exp_t e;
                    logic [BUF_BYTES*8-1:0] eb;
                    e = sb.pop_front();
                    eb = '0;
                    for (int i = 0; i < e.txt.len(); i++) eb[i*8 +: 8] = e.txt[i];
                    check(int'(cmd_code) == e.code, e.req, "code", int'(cmd_code), e.code);
                    check(int'(cmd_err) == e.err, e.req, "err", int'(cmd_err), e.err);
                    if (e.full) begin
                        check(int'(cmd_form) == e.form, e.req, "form", int'(cmd_form), e.form);
                        check(int'(cmd_nparams) == e.np, e.req, "nparams", int'(cmd_nparams), e.np);
                        check(int'(cmd_len) == e.txt.len(), e.req, "len", int'(cmd_len), e.txt.len());
                        check(cmd_params == eb, e.req, "params differ, len", int'(cmd_len), e.txt.len());
                    end
                end
            end
            held = cmd_valid && !cmd_ready;
            p_code = cmd_code; p_err = cmd_err; p_len = cmd_len;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        string s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(cmd_valid === 1'b0, "R1", "cmd_valid", int'(cmd_valid), 0);
        check(rx_ready === 1'b1, "R1", "rx_ready", int'(rx_ready), 1);

        // R2 bare line, then empty lines give nothing
        ok_line("R2", "AT\r", 0, 0, 0, "");
        send("\n", 1'b0, "R2");
        send("\r\n", 1'b0, "R2");
        repeat (4) @(negedge clk);
        check(cmd_valid === 1'b0, "R2", "result from empty line", int'(cmd_valid), 0);

        // R3 case and codes
        ok_line("R3", "at+rst\r", 13, 0, 0, "");
        ok_line("R3", "At+cIpMuX=1\r", 3, 1, 1, "1");
        ok_line("R3", "AT+CIPSTATUS\n", 7, 0, 0, "");

        // R4 forms
        ok_line("R4", "AT+CWMODE?\n", 10, 2, 0, "");
        ok_line("R4", "AT+CWMODE=?\r", 10, 3, 0, "");
        err_line("R4", "AT+CWMODE?x\r", 10, 3);
        err_line("R4", "AT+CWMODE=?1\r", 10, 3);

        // R5 field text
        ok_line("R5", "AT+CWMODE=3\r", 10, 1, 1, "3");
        ok_line("R5", "AT+CIPSTART=4,\"TCP\",\"1.2.3.4\",9999\r", 6, 1, 4,
                "4,\"TCP\",\"1.2.3.4\",9999");

        // R6 quoting
        ok_line("R6", "AT+CWJAP=\"a,b\",\"pw\"\r", 8, 1, 2, "\"a,b\",\"pw\"");
        err_line("R6", "AT+CWJAP=ab\"c\"\r", 8, 3);
        err_line("R6", "AT+CWJAP=\"a\"b\r", 8, 3);

        // R7 spaces next to quotes
        err_line("R7", "AT+CWJAP=\" x\",\"p\"\r", 8, 3);
        err_line("R7", "AT+CWJAP=\"x \",\"p\"\r", 8, 3);
        err_line("R7", "AT+CWJAP=\"x\r", 8, 3);
        ok_line("R7", "AT+CWSAP=\"a b\",\"\"\r", 12, 1, 2, "\"a b\",\"\"");

        // R8 names
        err_line("R8", "AT+FOO\r", 15, 2);
        err_line("R8", "AT+\r", 15, 2);
        err_line("R8", "AT+CIPSERVERX\r", 15, 2);
        err_line("R8", "AT+CW-MODE\r", 15, 2);

        // R9 prefix
        err_line("R9", "XT\r", 15, 1);
        err_line("R9", "A\r", 15, 1);

        // R10 range rules
        err_line("R10", "AT+CWMODE=4\r", 10, 4);
        err_line("R10", "AT+CWMODE=0\r", 10, 4);
        err_line("R10", "AT+CWMODE=\"1\"\r", 10, 4);
        err_line("R10", "AT+CIPSTART=5,\"TCP\",\"h\",1\r", 6, 4);
        ok_line("R10", "AT+CIPSTART=\"UDP\",\"h\",7\r", 6, 1, 3, "\"UDP\",\"h\",7");
        ok_line("R10", "AT+CIPSEND=15\r", 4, 1, 1, "15");
        ok_line("R10", "AT+CIPSEND=4,15\r", 4, 1, 2, "4,15");
        err_line("R10", "AT+CIPSEND=7,3\r", 4, 4);
        err_line("R10", "AT+CIPCLOSE=12\r", 2, 4);
        ok_line("R10", "AT+CIPCLOSE=0\r", 2, 1, 1, "0");

        // R11 buffer and field limits, then recovery
        s = "\"";
        for (int i = 0; i < 30; i++) s = {s, "a"};
        s = {s, "\""};
        ok_line("R11", {"AT+CWJAP=", s, "\r"}, 8, 1, 1, s);
        s = "";
        for (int i = 0; i < 33; i++) s = {s, "x"};
        err_line("R11", {"AT+CWJAP=", s, "\r"}, 8, 5);
        ok_line("R11", "AT+CIFSR=1,2,3,4,5\r", 1, 1, 5, "1,2,3,4,5");
        err_line("R11", "AT+CIFSR=1,2,3,4,5,6\r", 1, 5);
        ok_line("R11", "AT\n", 0, 0, 0, "");

        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule